// File: doc/BRIEF.md
# PHY Control Register Bank with Bit-Masked Writes

This block holds the static configuration of a four-lane serial display transmitter PHY. It has twelve 16-bit control words and two 16-bit status words. It is reached through a plain single-cycle port with a valid strobe, a write flag, a byte address and a 32-bit data word. Each write carries its own per-bit enable: the upper half of the bus word selects which bits of the lower half are taken. Firmware can therefore change one field, such as a power-down bit or a lane's amplitude, in a single write without first reading the register back.

Every control field goes straight from its storage flop to a decoded output port, so the PHY logic sees a change on the clock edge after the write. Reads return one word on the cycle after the request. A control word reads back its stored contents. A status word reads back the live PHY status inputs at that edge; bit 0 of the first status word is the PLL-ready flag. Reset puts the PHY fully powered down.

Top module: `phy_cfg_bank`

## Requirements
- R1: After reset, word 0x00 reads 0x0FF1 and word 0x28 reads 0x0007, with every lane idle, every lane powered down, PLL power-down set and all AUX power-down and idle bits set. Every other control word reads 0x0000.
- R2: A write to a control word at address A with bus word {M[15:0], D[15:0]} turns stored value Q into (Q & ~M) | (D & M). The new value is seen on the field outputs one clock after the write edge.
- R3: A write whose mask half is 0x0000 leaves the addressed word and all field outputs unchanged.
- R4: Word 0x00 drives the lane idle bits from bits 11:8, the lane power-down bits from 7:4, the IDDQ enable from bit 1 and the PLL power-down from bit 0. Lane n uses the bit at offset n of its field.
- R5: Word 0x04 bits 14:0 drive the PLL feedback divider. Word 0x08 drives TX termination from bits 10:8, the rate select from 5:4 and the reference divider from 3:0.
- R6: Lane n takes its pre-emphasis from word 0x0C bits 4n+3:4n, its amplitude from word 0x10 bits 4n+2:4n, and its amplitude scale from word 0x14 bits 2n+1:2n. Word 0x14 bits 9:8 drive the TX mode. The packed amplitude output puts lane n at bits 3n+2:3n.
- R7: Word 0x18 drives the spread-spectrum depth from bits 15:12, the spread-spectrum enable from bit 11 and the spread-spectrum count from bits 9:0.
- R8: Words 0x1C, 0x20 and 0x24 drive three raw 16-bit control outputs. Word 0x28 drives the AUX receiver power-down select (bit 5), driver power-down select (bit 4), idle (bit 2), receiver power-down (bit 1) and driver power-down (bit 0). Word 0x2C drives the AUX receiver common mode (14:12), mode (11:10), amplitude scale (9:8), amplitude (6:4) and termination (2:0).
- R9: A read of a control word puts the stored 16 bits on read-data bits 15:0, with bits 31:16 zero, one clock after the request edge.
- R10: Reads of 0x30 and 0x34 return the first and second status inputs as sampled at the request edge, with bit 0 of 0x30 being PLL ready. Writes to either address change nothing.
- R11: An access to an address whose low two bits are nonzero, or that lies at or above 0x38, reads back zero, and a write to it changes no control word.
- R12: Read data changes only on the clock edge of a read request. Between requests, and during writes, it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Bits 31:16 are the bit mask, bits 15:0 the data |
| bus_rdata | output | 32 | Read data, registered |
| status0_in | input | 16 | Status word 0x30, bit 0 is PLL ready |
| status1_in | input | 16 | Status word 0x34 |
| tx_idle | output | 4 | Per-lane transmitter idle |
| tx_pd | output | 4 | Per-lane transmitter power-down |
| iddq_en | output | 1 | Quiescent-current test enable |
| pll_pd | output | 1 | PLL power-down |
| pll_div | output | 15 | PLL feedback divider |
| tx_rterm | output | 3 | TX termination trim |
| rate_sel | output | 2 | Link rate select |
| ref_div | output | 4 | Reference divider |
| tx_emph | output | 16 | Pre-emphasis, 4 bits per lane |
| tx_amp | output | 12 | Amplitude, 3 bits per lane |
| tx_amp_scale | output | 8 | Amplitude scale, 2 bits per lane |
| tx_mode | output | 2 | TX mode |
| ssc_depth | output | 4 | Spread-spectrum depth |
| ssc_en | output | 1 | Spread-spectrum enable |
| ssc_cnt | output | 10 | Spread-spectrum count |
| spare_ctl | output | 16 | Raw control word 0x1C |
| pll_ctl | output | 16 | Raw control word 0x20 |
| tx_ctl | output | 16 | Raw control word 0x24 |
| aux_rx_pd_sel | output | 1 | AUX receiver power-down select |
| aux_tx_pd_sel | output | 1 | AUX driver power-down select |
| aux_idle | output | 1 | AUX idle |
| aux_rx_pd | output | 1 | AUX receiver power-down |
| aux_tx_pd | output | 1 | AUX driver power-down |
| aux_rx_vcm | output | 3 | AUX receiver common mode |
| aux_mode | output | 2 | AUX mode |
| aux_amp_scale | output | 2 | AUX amplitude scale |
| aux_amp | output | 3 | AUX amplitude |
| aux_rterm | output | 3 | AUX termination |

## Verification
A write has a one-edge latency: the field outputs take the new value on the same rising edge that samples the write. A read has the same latency: read data is loaded on the request edge and then holds. The bench drives every request on a falling edge and removes it on the next falling edge. It samples field outputs and read data on that second falling edge, which is half a cycle after the single register stage, so each check reads a settled value. Status reads are checked with the status inputs held constant across the request edge. The hold behaviour is checked at the falling edges after idle cycles and after writes.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

   localparam int unsigned WORD_BITS = 16;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_STAT = 2'd2
   } rd_sel_e;

   // Reset value per control word index: PHY comes up fully powered down.
   function automatic logic [WORD_BITS-1:0] ctrl_reset(input int idx);
      case (idx)
         0:       return 16'h0FF1;  // lanes idle + powered down, PLL down
         10:      return 16'h0007;  // AUX idle, receiver and driver down
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/phy_cfg_decode.sv
module phy_cfg_decode
   import phy_cfg_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int NUM_CTRL = 12,
   parameter int NUM_STAT = 2
) (
   input  logic                bus_valid,
   input  logic                bus_write,
   input  logic [ADDR_W-1:0]   bus_addr,
   output logic [NUM_CTRL-1:0] ctrl_we,
   output logic                rd_en,
   output rd_sel_e             rd_sel,
   output logic [ADDR_W-3:0]   rd_idx
);
   localparam int IDX_W = ADDR_W - 2;

   logic             aligned;
   logic [IDX_W-1:0] idx;
   logic             hit_ctrl;
   logic             hit_stat;

   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign idx      = bus_addr[ADDR_W-1:2];
   assign hit_ctrl = aligned && (idx < IDX_W'(NUM_CTRL));
   assign hit_stat = aligned && (idx >= IDX_W'(NUM_CTRL)) &&
                     (idx < IDX_W'(NUM_CTRL + NUM_STAT));

   for (genvar g = 0; g < NUM_CTRL; g++) begin : g_we
      assign ctrl_we[g] = bus_valid & bus_write & hit_ctrl & (idx == IDX_W'(g));
   end

   assign rd_en  = bus_valid & ~bus_write;
   assign rd_idx = idx;

   always_comb begin
      if (hit_ctrl)      rd_sel = SEL_CTRL;
      else if (hit_stat) rd_sel = SEL_STAT;
      else               rd_sel = SEL_NONE;
   end

endmodule

// File: rtl/phy_cfg_word.sv
module phy_cfg_word #(
   parameter int               WORD_W = 16,
   parameter logic [WORD_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WORD_W-1:0] mask,
   input  logic [WORD_W-1:0] data,
   output logic [WORD_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= (q & ~mask) | (data & mask);
   end
endmodule

// File: rtl/phy_cfg_rdmux.sv
module phy_cfg_rdmux
   import phy_cfg_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int NUM_CTRL = 12,
   parameter int NUM_STAT = 2,
   parameter int IDX_W    = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd_en,
   input  rd_sel_e                      rd_sel,
   input  logic [IDX_W-1:0]             rd_idx,
   input  logic [NUM_CTRL*WORD_W-1:0]   ctrl_flat,
   input  logic [NUM_STAT*WORD_W-1:0]   stat_flat,
   output logic [2*WORD_W-1:0]          rdata
);
   logic [WORD_W-1:0] word;

   always_comb begin
      word = '0;
      if (rd_sel == SEL_CTRL) begin
         for (int i = 0; i < NUM_CTRL; i++)
            if (rd_idx == IDX_W'(i)) word = ctrl_flat[i*WORD_W +: WORD_W];
      end else if (rd_sel == SEL_STAT) begin
         for (int i = 0; i < NUM_STAT; i++)
            if (rd_idx == IDX_W'(NUM_CTRL + i)) word = stat_flat[i*WORD_W +: WORD_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= {{WORD_W{1'b0}}, word};
   end
endmodule

// File: rtl/phy_cfg_bank.sv
module phy_cfg_bank
   import phy_cfg_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int WORD_W   = 16,
   parameter int NUM_CTRL = 12,
   parameter int LANES    = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_valid,
   input  logic                   bus_write,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [2*WORD_W-1:0]    bus_wdata,
   output logic [2*WORD_W-1:0]    bus_rdata,
   input  logic [WORD_W-1:0]      status0_in,
   input  logic [WORD_W-1:0]      status1_in,
   output logic [LANES-1:0]       tx_idle,
   output logic [LANES-1:0]       tx_pd,
   output logic                   iddq_en,
   output logic                   pll_pd,
   output logic [14:0]            pll_div,
   output logic [2:0]             tx_rterm,
   output logic [1:0]             rate_sel,
   output logic [3:0]             ref_div,
   output logic [4*LANES-1:0]     tx_emph,
   output logic [3*LANES-1:0]     tx_amp,
   output logic [2*LANES-1:0]     tx_amp_scale,
   output logic [1:0]             tx_mode,
   output logic [3:0]             ssc_depth,
   output logic                   ssc_en,
   output logic [9:0]             ssc_cnt,
   output logic [WORD_W-1:0]      spare_ctl,
   output logic [WORD_W-1:0]      pll_ctl,
   output logic [WORD_W-1:0]      tx_ctl,
   output logic                   aux_rx_pd_sel,
   output logic                   aux_tx_pd_sel,
   output logic                   aux_idle,
   output logic                   aux_rx_pd,
   output logic                   aux_tx_pd,
   output logic [2:0]             aux_rx_vcm,
   output logic [1:0]             aux_mode,
   output logic [1:0]             aux_amp_scale,
   output logic [2:0]             aux_amp,
   output logic [2:0]             aux_rterm
);
   localparam int NUM_STAT = 2;
   localparam int IDX_W    = ADDR_W - 2;

   // Elaboration-time parameter checks
   if (WORD_W != WORD_BITS) begin : g_bad_word
      $error("phy_cfg_bank: WORD_W must be %0d", WORD_BITS);
   end
   if (NUM_CTRL != 12) begin : g_bad_ctrl
      $error("phy_cfg_bank: field map assumes 12 control words");
   end
   if (LANES != 4) begin : g_bad_lanes
      $error("phy_cfg_bank: field map assumes 4 lanes");
   end
   if ((NUM_CTRL + NUM_STAT) * 4 > (1 << ADDR_W)) begin : g_bad_addr
      $error("phy_cfg_bank: ADDR_W too small for the register map");
   end

   logic [NUM_CTRL-1:0]        ctrl_we;
   logic                       rd_en;
   rd_sel_e                    rd_sel;
   logic [IDX_W-1:0]           rd_idx;
   logic [WORD_W-1:0]          ctrl_q [NUM_CTRL];
   logic [NUM_CTRL*WORD_W-1:0] ctrl_flat;

   phy_cfg_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_CTRL (NUM_CTRL),
      .NUM_STAT (NUM_STAT)
   ) u_dec (
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .ctrl_we   (ctrl_we),
      .rd_en     (rd_en),
      .rd_sel    (rd_sel),
      .rd_idx    (rd_idx)
   );

   for (genvar g = 0; g < NUM_CTRL; g++) begin : g_word
      phy_cfg_word #(
         .WORD_W  (WORD_W),
         .RST_VAL (WORD_W'(ctrl_reset(g)))
      ) u_word (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (ctrl_we[g]),
         .mask  (bus_wdata[2*WORD_W-1:WORD_W]),
         .data  (bus_wdata[WORD_W-1:0]),
         .q     (ctrl_q[g])
      );
      assign ctrl_flat[g*WORD_W +: WORD_W] = ctrl_q[g];
   end

   phy_cfg_rdmux #(
      .WORD_W   (WORD_W),
      .NUM_CTRL (NUM_CTRL),
      .NUM_STAT (NUM_STAT),
      .IDX_W    (IDX_W)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .rd_sel    (rd_sel),
      .rd_idx    (rd_idx),
      .ctrl_flat (ctrl_flat),
      .stat_flat ({status1_in, status0_in}),
      .rdata     (bus_rdata)
   );

   // Word 0x00: power and idle
   assign tx_idle  = ctrl_q[0][8 +: LANES];
   assign tx_pd    = ctrl_q[0][4 +: LANES];
   assign iddq_en  = ctrl_q[0][1];
   assign pll_pd   = ctrl_q[0][0];
   // Words 0x04, 0x08: PLL setup
   assign pll_div  = ctrl_q[1][14:0];
   assign tx_rterm = ctrl_q[2][10:8];
   assign rate_sel = ctrl_q[2][5:4];
   assign ref_div  = ctrl_q[2][3:0];
   // Words 0x0C, 0x10, 0x14: per-lane drive
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign tx_emph[4*l +: 4]      = ctrl_q[3][4*l +: 4];
      assign tx_amp[3*l +: 3]       = ctrl_q[4][4*l +: 3];
      assign tx_amp_scale[2*l +: 2] = ctrl_q[5][2*l +: 2];
   end
   assign tx_mode   = ctrl_q[5][9:8];
   // Word 0x18: spread spectrum
   assign ssc_depth = ctrl_q[6][15:12];
   assign ssc_en    = ctrl_q[6][11];
   assign ssc_cnt   = ctrl_q[6][9:0];
   // Words 0x1C..0x24: raw words
   assign spare_ctl = ctrl_q[7];
   assign pll_ctl   = ctrl_q[8];
   assign tx_ctl    = ctrl_q[9];
   // Words 0x28, 0x2C: AUX channel
   assign aux_rx_pd_sel = ctrl_q[10][5];
   assign aux_tx_pd_sel = ctrl_q[10][4];
   assign aux_idle      = ctrl_q[10][2];
   assign aux_rx_pd     = ctrl_q[10][1];
   assign aux_tx_pd     = ctrl_q[10][0];
   assign aux_rx_vcm    = ctrl_q[11][14:12];
   assign aux_mode      = ctrl_q[11][11:10];
   assign aux_amp_scale = ctrl_q[11][9:8];
   assign aux_amp       = ctrl_q[11][6:4];
   assign aux_rterm     = ctrl_q[11][2:0];

endmodule

// File: rtl/phy_cfg_bank_chk.sv
module phy_cfg_bank_chk #(
   parameter int ADDR_W   = 8,
   parameter int NUM_CTRL = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [15:0]       status0_in,
   input logic [3:0]        tx_idle,
   input logic [3:0]        tx_pd,
   input logic              pll_pd,
   input logic [14:0]       pll_div,
   input logic [9:0]        ssc_cnt
);
   localparam logic [ADDR_W-1:0] END_ADDR  = ADDR_W'((NUM_CTRL + 2) * 4);
   localparam logic [ADDR_W-1:0] STAT0_ADR = ADDR_W'(NUM_CTRL * 4);

   logic wr, rd;
   assign wr = bus_valid & bus_write;
   assign rd = bus_valid & ~bus_write;

   AST_MASK_BIT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == '0 && bus_wdata[16]) |=> (pll_pd == $past(bus_wdata[0]))); // R2

   AST_MASK_BIT_CLEAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == '0 && !bus_wdata[16]) |=> $stable(pll_pd)); // R3

   AST_ZERO_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_wdata[31:16] == 16'h0) |=> $stable({tx_idle, tx_pd, pll_pd, pll_div, ssc_cnt})); // R3

   AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable({tx_idle, tx_pd, pll_pd, pll_div, ssc_cnt})); // R2

   AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[31:16] == 16'h0); // R9

   AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == STAT0_ADR) |=> (bus_rdata == {16'h0, $past(status0_in)})); // R10

   AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (bus_addr[1:0] != 2'b00 || bus_addr >= END_ADDR)) |=> (bus_rdata == 32'h0)); // R11

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(bus_rdata)); // R12

endmodule

bind phy_cfg_bank phy_cfg_bank_chk #(
   .ADDR_W   (ADDR_W),
   .NUM_CTRL (NUM_CTRL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_valid  (bus_valid),
   .bus_write  (bus_write),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .status0_in (status0_in),
   .tx_idle    (tx_idle),
   .tx_pd      (tx_pd),
   .pll_pd     (pll_pd),
   .pll_div    (pll_div),
   .ssc_cnt    (ssc_cnt)
);

// File: tb/tb_phy_cfg_bank.sv
module tb_phy_cfg_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] status0_in = '0;
   logic [15:0] status1_in = '0;
   logic [3:0]  tx_idle, tx_pd;
   logic        iddq_en, pll_pd;
   logic [14:0] pll_div;
   logic [2:0]  tx_rterm;
   logic [1:0]  rate_sel;
   logic [3:0]  ref_div;
   logic [15:0] tx_emph;
   logic [11:0] tx_amp;
   logic [7:0]  tx_amp_scale;
   logic [1:0]  tx_mode;
   logic [3:0]  ssc_depth;
   logic        ssc_en;
   logic [9:0]  ssc_cnt;
   logic [15:0] spare_ctl, pll_ctl, tx_ctl;
   logic        aux_rx_pd_sel, aux_tx_pd_sel, aux_idle, aux_rx_pd, aux_tx_pd;
   logic [2:0]  aux_rx_vcm;
   logic [1:0]  aux_mode, aux_amp_scale;
   logic [2:0]  aux_amp, aux_rterm;

   int checks = 0;
   int errors = 0;
   logic [15:0] shadow [12];

   always #5 clk = ~clk;

   phy_cfg_bank dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .status0_in(status0_in), .status1_in(status1_in),
      .tx_idle(tx_idle), .tx_pd(tx_pd), .iddq_en(iddq_en), .pll_pd(pll_pd),
      .pll_div(pll_div), .tx_rterm(tx_rterm), .rate_sel(rate_sel), .ref_div(ref_div),
      .tx_emph(tx_emph), .tx_amp(tx_amp), .tx_amp_scale(tx_amp_scale), .tx_mode(tx_mode),
      .ssc_depth(ssc_depth), .ssc_en(ssc_en), .ssc_cnt(ssc_cnt),
      .spare_ctl(spare_ctl), .pll_ctl(pll_ctl), .tx_ctl(tx_ctl),
      .aux_rx_pd_sel(aux_rx_pd_sel), .aux_tx_pd_sel(aux_tx_pd_sel), .aux_idle(aux_idle),
      .aux_rx_pd(aux_rx_pd), .aux_tx_pd(aux_tx_pd), .aux_rx_vcm(aux_rx_vcm),
      .aux_mode(aux_mode), .aux_amp_scale(aux_amp_scale), .aux_amp(aux_amp),
      .aux_rterm(aux_rterm)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive on a falling edge, release on the next; outputs settled after that.
   task automatic bus_wr(input logic [7:0] a, input logic [15:0] m, input logic [15:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = {m, d};
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      if (a[1:0] == 2'b00 && a < 8'h30)
         shadow[a[7:2]] = (shadow[a[7:2]] & ~m) | (d & m);
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = '0;
      @(negedge clk);
      bus_valid = 1'b0;
      v = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      bus_rd(8'h00, v); chk("R1 word00", v, 32'h0000_0FF1);
      bus_rd(8'h28, v); chk("R1 word28", v, 32'h0000_0007);
      bus_rd(8'h04, v); chk("R1 word04", v, 32'h0);
      bus_rd(8'h2C, v); chk("R1 word2C", v, 32'h0);
      chk("R1 power outputs", {23'h0, tx_idle, tx_pd, pll_pd},
          {23'h0, 4'hF, 4'hF, 1'b1});
      chk("R1 aux outputs", {27'h0, aux_idle, aux_rx_pd, aux_tx_pd, aux_rx_pd_sel, aux_tx_pd_sel},
          {27'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
   endtask

   task automatic t_masked();
      logic [31:0] v;
      bus_wr(8'h00, 16'h0001, 16'h0000);
      chk("R2 pll_pd cleared", {31'h0, pll_pd}, 32'h0);
      chk("R2 lanes untouched", {24'h0, tx_idle, tx_pd}, 32'h0000_00FF);
      bus_wr(8'h00, 16'h0F00, 16'h0A55);
      chk("R4 tx_idle", {28'h0, tx_idle}, 32'hA);
      chk("R4 tx_pd kept", {28'h0, tx_pd}, 32'hF);
      bus_wr(8'h00, 16'h00F2, 16'h0032);
      chk("R4 tx_pd+iddq", {27'h0, tx_pd, iddq_en}, {27'h0, 4'h3, 1'b1});
      bus_rd(8'h00, v); chk("R2 readback 00", v, {16'h0, shadow[0]});
   endtask

   task automatic t_zero_mask();
      logic [31:0] v;
      bus_wr(8'h04, 16'h0000, 16'h7FFF);
      chk("R3 pll_div", {17'h0, pll_div}, 32'h0);
      bus_wr(8'h00, 16'h0000, 16'hFFFF);
      bus_rd(8'h00, v); chk("R3 word00", v, {16'h0, shadow[0]});
   endtask

   task automatic t_pll();
      bus_wr(8'h04, 16'hFFFF, 16'h4380);
      chk("R5 pll_div", {17'h0, pll_div}, 32'h4380);
      bus_wr(8'h08, 16'hFFFF, 16'h0712);
      chk("R5 word08 fields", {23'h0, tx_rterm, rate_sel, ref_div}, {23'h0, 3'd7, 2'd1, 4'd2});
   endtask

   task automatic t_lanes();
      bus_wr(8'h0C, 16'hFFFF, 16'hD864);
      chk("R6 tx_emph", {16'h0, tx_emph}, 32'hD864);
      bus_wr(8'h10, 16'hFFFF, 16'h7531);
      chk("R6 tx_amp", {20'h0, tx_amp}, {20'h0, 3'd7, 3'd5, 3'd3, 3'd1});
      bus_wr(8'h14, 16'hFFFF, 16'h03E4);
      chk("R6 mode+scale", {22'h0, tx_mode, tx_amp_scale}, {22'h0, 2'd3, 8'hE4});
      bus_wr(8'h10, 16'h0070, 16'h0020);
      chk("R6 lane1 amp only", {20'h0, tx_amp}, {20'h0, 3'd7, 3'd5, 3'd2, 3'd1});
   endtask

   task automatic t_ssc();
      bus_wr(8'h18, 16'hFFFF, 16'h997D);
      chk("R7 ssc fields", {17'h0, ssc_depth, ssc_en, ssc_cnt}, {17'h0, 4'h9, 1'b1, 10'h17D});
      bus_wr(8'h18, 16'h0800, 16'h0000);
      chk("R7 ssc_en off", {17'h0, ssc_depth, ssc_en, ssc_cnt}, {17'h0, 4'h9, 1'b0, 10'h17D});
   endtask

   task automatic t_aux();
      logic [31:0] v;
      bus_wr(8'h1C, 16'hFFFF, 16'h1234);
      bus_wr(8'h20, 16'hFFFF, 16'h0800);
      bus_wr(8'h24, 16'hFFFF, 16'hBEEF);
      chk("R8 raw words", {spare_ctl, pll_ctl}, 32'h1234_0800);
      chk("R8 tx_ctl", {16'h0, tx_ctl}, 32'hBEEF);
      bus_wr(8'h28, 16'h0037, 16'h0030);
      chk("R8 aux word28", {27'h0, aux_rx_pd_sel, aux_tx_pd_sel, aux_idle, aux_rx_pd, aux_tx_pd},
          {27'h0, 5'b11000});
      bus_wr(8'h2C, 16'hFFFF, 16'h4513);
      chk("R8 aux word2C", {19'h0, aux_rx_vcm, aux_mode, aux_amp_scale, aux_amp, aux_rterm},
          {19'h0, 3'd4, 2'd1, 2'd1, 3'd1, 3'd3});
      bus_rd(8'h28, v); chk("R9 read 28", v, 32'h0000_0030);
      bus_rd(8'h24, v); chk("R9 read 24", v, 32'h0000_BEEF);
   endtask

   task automatic t_status();
      logic [31:0] v;
      status0_in = 16'h0001; status1_in = 16'hA5C3;
      bus_rd(8'h30, v); chk("R10 pll ready", v, 32'h0000_0001);
      bus_rd(8'h34, v); chk("R10 status1", v, 32'h0000_A5C3);
      bus_wr(8'h30, 16'hFFFF, 16'h0000);
      bus_wr(8'h34, 16'hFFFF, 16'h0000);
      bus_rd(8'h30, v); chk("R10 write ignored", v, 32'h0000_0001);
      status0_in = 16'h0000;
      bus_rd(8'h30, v); chk("R10 pll not ready", v, 32'h0);
      for (int i = 0; i < 12; i++) begin
         bus_rd(8'(i * 4), v); chk("R10 ctrl intact", v, {16'h0, shadow[i]});
      end
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      bus_rd(8'h38, v); chk("R11 read 38", v, 32'h0);
      bus_rd(8'h01, v); chk("R11 read misaligned", v, 32'h0);
      bus_rd(8'hFC, v); chk("R11 read FC", v, 32'h0);
      bus_wr(8'h02, 16'hFFFF, 16'h0000);
      bus_wr(8'h3C, 16'hFFFF, 16'h0000);
      bus_rd(8'h00, v); chk("R11 word00 intact", v, {16'h0, shadow[0]});
      chk("R11 pll_pd intact", {31'h0, pll_pd}, {31'h0, shadow[0][0]});
   endtask

   task automatic t_hold();
      logic [31:0] v;
      bus_rd(8'h04, v); chk("R12 read 04", v, 32'h0000_4380);
      repeat (3) @(negedge clk);
      chk("R12 hold idle", bus_rdata, 32'h0000_4380);
      bus_wr(8'h08, 16'hFFFF, 16'h0101);
      chk("R12 hold on write", bus_rdata, 32'h0000_4380);
   endtask

   initial begin
      shadow[0] = 16'h0FF1;
      for (int i = 1; i < 12; i++) shadow[i] = 16'h0;
      shadow[10] = 16'h0007;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_masked();
      t_zero_mask();
      t_pll();
      t_lanes();
      t_ssc();
      t_aux();
      t_status();
      t_unmapped();
      t_hold();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule